// File: doc/BRIEF.md
# Aging-Aware Variable-Latency Multiplier Controller

This block wraps an unsigned m-by-m multiplier (m = 16 by default, 8 also supported) and decides, for each accepted operation, whether the product may be taken after one cycle or needs two. The decision comes from the number of zero bits in the multiplicand. A multiplicand with many zeros skips most adder cells in a bypassing array, so its path is short. Two comparators judge the zero count against a relaxed and a strict limit. An aging tracker chooses which of the two verdicts applies.

A timing-error input stands in for the shadow-latch comparison of an error-detecting flip-flop bank. It is sampled in the cycle the registered product is presented. If it is high, the product is discarded and the operation runs again on the stored operands, always over two cycles. Each such error advances the aging counter. When the counter reaches its limit it starts over and a sticky aged flag is set. From then until reset the strict limit applies, so fewer operations are treated as short.

Operands enter through a valid/ready handshake. The product leaves on a 2m-bit bus qualified by a one-cycle done strobe.

Top module: `vl_mult_ctrl`

## Requirements
- R1: When done is high, prod equals the unsigned product of the op_a and op_b values captured at acceptance, in both the 16-bit and the 8-bit configuration (for example 16'hD295 times 16'hAF25 gives 32'h90124A89).
- R2: in_ready is high only while no operation is in flight. It drops in the cycle after acceptance, stays low through the done cycle, and is high again in the cycle after done.
- R3: With aged low, an operation whose op_a holds at least ZTHRESH zero bits shows done in the first cycle after the accepting clock edge. Any other operation shows done in the second cycle.
- R4: With aged high, the short path requires at least ZTHRESH+1 zero bits in op_a. Otherwise the timing is as in R3.
- R5: A high timing_err in a cycle where the product is presented suppresses done and re-executes the operation. The next presentation comes two cycles later. timing_err in any other cycle has no effect on done, on latency or on the aging state.
- R6: done is high for exactly one cycle per accepted operation.
- R7: Every error counted under R5 advances the aging counter. The AGE_LIMIT-th error sets aged and restarts the count. aged then stays high until reset.
- R8: A synchronous active-high rst leaves in_ready high, done low and aged low, and clears the aging count, so that afterwards AGE_LIMIT errors are again needed to set aged.
- R9: Changes on op_a and op_b after the accepting edge do not affect the product or the latency of the operation in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand pair is offered |
| in_ready | output | 1 | Controller can accept an operand pair |
| op_a | input | WIDTH | Multiplicand; its zero bits set the latency |
| op_b | input | WIDTH | Multiplier operand |
| timing_err | input | 1 | Error flag for the product presented in this cycle |
| prod | output | 2*WIDTH | Registered product, valid when done is high |
| done | output | 1 | One-cycle strobe marking a final product |
| aged | output | 1 | Sticky flag: the strict latency limit is in use |

## Verification
The bench aims at the boundary of the zero-count limit. A multiplicand with exactly ZTHRESH zeros, such as 16'hD295, must be short while the block is fresh and long once it is aged. A block with an off-by-one comparison, or with the two verdicts swapped, shows done a cycle early or late. Errors are injected on presented products, including two in a row, and stray errors are raised in hold cycles. A design that counts stray errors sets aged too soon. One that reruns in a single cycle, or strobes done for the discarded product, breaks the cycle-exact done schedule. A reset after aging must bring back the relaxed limit and a cleared count. Operand buses are scrambled right after acceptance, so a design that reads them live returns a wrong product.

// File: rtl/vlm_pkg.sv
package vlm_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_HOLD = 2'd1,
      ST_CHK  = 2'd2
   } vlm_state_e;
endpackage

// File: rtl/vlm_zero_count.sv
module vlm_zero_count #(
   parameter int WIDTH = 16,
   localparam int CW = $clog2(WIDTH + 1)
) (
   input  logic [WIDTH-1:0] value,
   output logic [CW-1:0]    zeros
);
   always_comb begin
      zeros = '0;
      for (int i = 0; i < WIDTH; i++) begin
         zeros = zeros + {{(CW-1){1'b0}}, ~value[i]};
      end
   end
endmodule

// File: rtl/vlm_judge.sv
module vlm_judge #(
   parameter int CW    = 5,
   parameter int LIMIT = 8
) (
   input  logic [CW-1:0] zeros,
   output logic          one_cycle
);
   localparam logic [CW-1:0] LIM = CW'(LIMIT);
   assign one_cycle = (zeros >= LIM);
endmodule

// File: rtl/vlm_age_tracker.sv
module vlm_age_tracker #(
   parameter int AGE_LIMIT = 4,
   localparam int AW = $clog2(AGE_LIMIT + 1)
) (
   input  logic clk,
   input  logic rst,
   input  logic err_evt,
   output logic aged
);
   localparam logic [AW-1:0] LAST = AW'(AGE_LIMIT - 1);
   logic [AW-1:0] count;

   always_ff @(posedge clk) begin
      if (rst) begin
         count <= '0;
         aged  <= 1'b0;
      end else if (err_evt) begin
         if (count == LAST) begin
            count <= '0;
            aged  <= 1'b1;
         end else begin
            count <= count + 1'b1;
         end
      end
   end
endmodule

// File: rtl/vlm_mul_core.sv
module vlm_mul_core #(
   parameter int WIDTH     = 16,
   parameter bit ARRAY_IMPL = 1'b1,
   localparam int PW = 2 * WIDTH
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   output logic [PW-1:0]    p
);
   if (ARRAY_IMPL) begin : g_array
      logic [PW-1:0] acc [0:WIDTH];
      assign acc[0] = '0;
      for (genvar i = 0; i < WIDTH; i++) begin : g_row
         logic [PW-1:0] pp;
         assign pp = b[i] ? (PW'(a) << i) : '0;
         assign acc[i+1] = acc[i] + pp;
      end
      assign p = acc[WIDTH];
   end else begin : g_behav
      assign p = PW'(a) * PW'(b);
   end
endmodule

// File: rtl/vl_mult_ctrl.sv
module vl_mult_ctrl
   import vlm_pkg::*;
#(
   parameter int WIDTH      = 16,
   parameter int ZTHRESH    = WIDTH / 2,
   parameter int AGE_LIMIT  = 4,
   parameter bit ARRAY_IMPL = 1'b1
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               in_valid,
   output logic               in_ready,
   input  logic [WIDTH-1:0]   op_a,
   input  logic [WIDTH-1:0]   op_b,
   input  logic               timing_err,
   output logic [2*WIDTH-1:0] prod,
   output logic               done,
   output logic               aged
);
   localparam int PW = 2 * WIDTH;
   localparam int CW = $clog2(WIDTH + 1);

   if (WIDTH < 2) begin : g_bad_width
      $error("vl_mult_ctrl: WIDTH must be at least 2");
   end
   if (ZTHRESH < 0 || ZTHRESH >= WIDTH) begin : g_bad_thresh
      $error("vl_mult_ctrl: ZTHRESH must lie in 0..WIDTH-1");
   end
   if (AGE_LIMIT < 1) begin : g_bad_age
      $error("vl_mult_ctrl: AGE_LIMIT must be at least 1");
   end

   vlm_state_e        state;
   logic [WIDTH-1:0]  a_q, b_q;
   logic [PW-1:0]     prod_q;
   logic [WIDTH-1:0]  mul_a, mul_b;
   logic [PW-1:0]     mul_p;
   logic [CW-1:0]     zeros;
   logic [1:0]        verdict;
   logic              short_op;
   logic              err_evt;

   assign mul_a = (state == ST_IDLE) ? op_a : a_q;
   assign mul_b = (state == ST_IDLE) ? op_b : b_q;

   vlm_mul_core #(.WIDTH(WIDTH), .ARRAY_IMPL(ARRAY_IMPL)) u_mul (
      .a(mul_a), .b(mul_b), .p(mul_p)
   );

   vlm_zero_count #(.WIDTH(WIDTH)) u_zc (
      .value(op_a), .zeros(zeros)
   );

   for (genvar g = 0; g < 2; g++) begin : g_judge
      vlm_judge #(.CW(CW), .LIMIT(ZTHRESH + g)) u_judge (
         .zeros(zeros), .one_cycle(verdict[g])
      );
   end

   assign short_op = aged ? verdict[1] : verdict[0];
   assign err_evt  = (state == ST_CHK) && timing_err;

   vlm_age_tracker #(.AGE_LIMIT(AGE_LIMIT)) u_age (
      .clk(clk), .rst(rst), .err_evt(err_evt), .aged(aged)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         state  <= ST_IDLE;
         a_q    <= '0;
         b_q    <= '0;
         prod_q <= '0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (in_valid) begin
                  a_q <= op_a;
                  b_q <= op_b;
                  if (short_op) begin
                     prod_q <= mul_p;
                     state  <= ST_CHK;
                  end else begin
                     state  <= ST_HOLD;
                  end
               end
            end
            ST_HOLD: begin
               prod_q <= mul_p;
               state  <= ST_CHK;
            end
            ST_CHK: begin
               state <= timing_err ? ST_HOLD : ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign in_ready = (state == ST_IDLE);
   assign done     = (state == ST_CHK) && !timing_err;
   assign prod     = prod_q;
endmodule

// File: rtl/vlm_checker.sv
module vlm_checker #(
   parameter int WIDTH      = 16,
   parameter int ZTHRESH    = WIDTH / 2,
   parameter int AGE_LIMIT  = 4,
   parameter bit ARRAY_IMPL = 1'b1
) (
   input logic               clk,
   input logic               rst,
   input logic               in_valid,
   input logic               in_ready,
   input logic [WIDTH-1:0]   op_a,
   input logic [WIDTH-1:0]   op_b,
   input logic               timing_err,
   input logic [2*WIDTH-1:0] prod,
   input logic               done,
   input logic               aged
);
   localparam int PW = 2 * WIDTH;
   logic [WIDTH-1:0] a_l, b_l;
   logic             accept;

   assign accept = in_valid && in_ready;

   always_ff @(posedge clk) begin
      if (rst) begin
         a_l <= '0;
         b_l <= '0;
      end else if (accept) begin
         a_l <= op_a;
         b_l <= op_b;
      end
   end

   // R1
   prod_match_chk: assert property (@(posedge clk) disable iff (rst)
      done |-> (prod == (PW'(a_l) * PW'(b_l))));

   // R2
   ready_drop_chk: assert property (@(posedge clk) disable iff (rst)
      accept |=> !in_ready);

   // R2
   done_busy_chk: assert property (@(posedge clk) disable iff (rst)
      done |-> !in_ready);

   // R6
   single_done_chk: assert property (@(posedge clk) disable iff (rst)
      done |=> (!done && in_ready));

   // R5
   err_blocks_done_chk: assert property (@(posedge clk) disable iff (rst)
      timing_err |-> !done);

   // R7
   aged_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      aged |=> aged);

   // R8
   reset_state_chk: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (in_ready && !aged && !done));
endmodule

bind vl_mult_ctrl vlm_checker #(
   .WIDTH(WIDTH), .ZTHRESH(ZTHRESH), .AGE_LIMIT(AGE_LIMIT), .ARRAY_IMPL(ARRAY_IMPL)
) u_vlm_chk (.*);

// File: tb/tb_vl_mult_ctrl.sv
`timescale 1ns/1ps
module tb_vl_mult_ctrl;
   localparam int W   = 16;
   localparam int N   = W / 2;
   localparam int LIM = 4;
   localparam int PW  = 2 * W;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          in_valid = 1'b0;
   logic          in_ready;
   logic [W-1:0]  op_a = '0;
   logic [W-1:0]  op_b = '0;
   logic          timing_err = 1'b0;
   logic [PW-1:0] prod;
   logic          done;
   logic          aged;

   int compared = 0;
   int mismatched = 0;
   int age_cnt = 0;
   bit aged_m = 1'b0;

   always #2 clk = ~clk;

   vl_mult_ctrl dut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
      .op_a(op_a), .op_b(op_b), .timing_err(timing_err),
      .prod(prod), .done(done), .aged(aged)
   );

   function automatic int zeros_of(input logic [W-1:0] v);
      int z = 0;
      for (int i = 0; i < W; i++) if (!v[i]) z++;
      return z;
   endfunction

   function automatic logic [PW-1:0] mul_ref(input logic [W-1:0] a, input logic [W-1:0] b);
      logic [PW-1:0] acc = '0;
      for (int i = 0; i < W; i++) if (b[i]) acc = acc + (PW'(a) << i);
      return acc;
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      compared++;
      if (!ok) begin
         mismatched++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic model_err();
      if (age_cnt == LIM - 1) begin
         age_cnt = 0;
         aged_m  = 1'b1;
      end else begin
         age_cnt++;
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; in_valid = 1'b0; timing_err = 1'b0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      age_cnt = 0; aged_m = 1'b0;
      #1;
      chk(in_ready == 1'b1, "R8", "ready after reset", 64'(in_ready), 64'd1);
      chk(done == 1'b0, "R8", "done after reset", 64'(done), 64'd0);
      chk(aged == 1'b0, "R8", "aged after reset", 64'(aged), 64'd0);
   endtask

   // n_err errors on presented products; stray raises timing_err in hold cycles
   task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b,
                         input int n_err, input bit stray);
      logic [PW-1:0] exp_p = mul_ref(a, b);
      int lim_now = aged_m ? N + 1 : N;
      bit is_short = (zeros_of(a) >= lim_now);
      string lreq = aged_m ? "R4" : "R3";
      int next_present = is_short ? 1 : 2;
      int errs = n_err;
      int k = 1;
      bit fin = 1'b0;
      @(negedge clk);
      in_valid = 1'b1; op_a = a; op_b = b; timing_err = 1'b0;
      #1;
      chk(in_ready == 1'b1, "R2", "ready before accept", 64'(in_ready), 64'd1);
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      op_a = W'($urandom);  // R9: scramble after acceptance
      op_b = W'($urandom);
      while (!fin && k < 40) begin
         if (k == next_present) begin
            if (errs > 0) begin
               timing_err = 1'b1;
               #1;
               chk(done == 1'b0, "R5", "done under error", 64'(done), 64'd0);
               model_err();
               errs--;
               next_present += 2;
            end else begin
               timing_err = 1'b0;
               #1;
               chk(done == 1'b1, lreq, "done at expected cycle", 64'(done), 64'd1);
               chk(prod == exp_p, "R1", "product", 64'(prod), 64'(exp_p));
               chk(in_ready == 1'b0, "R2", "ready in done cycle", 64'(in_ready), 64'd0);
               fin = 1'b1;
            end
         end else begin
            timing_err = stray;
            #1;
            chk(done == 1'b0, stray ? "R5" : lreq, "early done", 64'(done), 64'd0);
            chk(in_ready == 1'b0, "R2", "ready while busy", 64'(in_ready), 64'd0);
         end
         if (!fin) begin
            @(posedge clk);
            @(negedge clk);
            k++;
         end
      end
      if (!fin) chk(1'b0, lreq, "done never seen", 64'(k), 64'(next_present));
      @(negedge clk);
      timing_err = 1'b0;
      #1;
      chk(done == 1'b0, "R6", "second done", 64'(done), 64'd0);
      chk(in_ready == 1'b1, "R2", "ready after done", 64'(in_ready), 64'd1);
      chk(aged == aged_m, "R7", "aged flag", 64'(aged), 64'(aged_m));
   endtask

   initial begin
      #(200000 * 4);
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_1234));
      do_reset();
      // R3 boundary: D295 has exactly N zeros -> short when fresh; R1 known product
      run_op(16'hD295, 16'hAF25, 0, 1'b0);
      chk(prod == 32'h90124A89, "R1", "known product", 64'(prod), 64'h90124A89);
      run_op(16'h01FF, 16'h1234, 0, 1'b0);  // N-1 zeros: long
      run_op(16'h007F, 16'hFFFF, 0, 1'b0);  // N+1 zeros: short
      run_op(16'h0000, 16'hBEEF, 0, 1'b0);
      run_op(16'hFFFF, 16'hFFFF, 0, 1'b0);
      for (int i = 0; i < 50; i++) run_op(W'($urandom), W'($urandom), 0, 1'b0);
      // R5 / R7: errors advance the counter, stray ones do not
      run_op(16'hD295, 16'h0003, 1, 1'b0);
      run_op(16'h01FF, 16'h7777, 2, 1'b0);
      run_op(16'hFFF0, 16'h0101, 0, 1'b1);
      chk(aged == 1'b0, "R7", "aged before limit", 64'(aged), 64'd0);
      run_op(16'h8001, 16'hABCD, 1, 1'b0);
      chk(aged == 1'b1, "R7", "aged at limit", 64'(aged), 64'd1);
      // R4 boundary: same operand now long, N+1 zeros still short
      run_op(16'hD295, 16'hAF25, 0, 1'b0);
      run_op(16'h007F, 16'h0F0F, 0, 1'b0);
      for (int i = 0; i < 50; i++)
         run_op(W'($urandom), W'($urandom), int'($urandom % 2), 1'b0);
      chk(aged == 1'b1, "R7", "aged stays", 64'(aged), 64'd1);
      // R8: reset restores the relaxed limit and clears the count
      do_reset();
      run_op(16'hD295, 16'hAF25, 0, 1'b0);
      run_op(16'h1234, 16'h4321, 3, 1'b0);
      chk(aged == 1'b0, "R8", "count cleared by reset", 64'(aged), 64'd0);
      run_op(16'h5555, 16'hAAAA, 1, 1'b0);
      chk(aged == 1'b1, "R7", "aged after limit again", 64'(aged), 64'd1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule